// File: doc/BRIEF.md
# Banked Word-Addressed Memory with Shared Read Bus

This block models a one-megabit memory built from 32 independent banks. Each bank holds 128 rows of 256 bits. It is accessed with 32-bit words. A 15-bit word address selects a bank, a row inside that bank, and one of the eight 32-bit word slots in that row. The read and write requests, the address and the write word are first captured in input registers. The access then takes place in the following cycle, and only the addressed bank is active.

Every bank decodes its row and picks its word with one eight-way selector per output bit. It latches the result into its own output register. The banks share one read bus, and only the bank that served the most recent read drives it. While no read is in progress, the bus keeps showing the last word read. A one-hot activity vector shows which bank is awake in a given cycle, so the other banks can be power gated.

Top module: `bank_sram`

## Requirements
- R1: While reset is asserted, and directly after it, `rdData` is zero and `blockActive` is all zeros.
- R2: The address splits as bits [14:10] = bank, bits [9:3] = row, bits [2:0] = word slot. Slot k covers row bits [32k+31:32k]. Distinct addresses hold distinct words.
- R3: Requests are registered. In the cycle after a read or write is presented, `blockActive` has exactly one bit set, the bit whose index is the bank field. In a cycle with no registered request, it is all zeros.
- R4: Read data appears on `rdData` after the second rising edge that follows the read request being presented.
- R5: A write replaces only the addressed 32-bit slot. The other seven slots of that row keep their contents.
- R6: When read and write are presented together, only the write is performed, and `rdData` keeps its previous value through that access.
- R7: When no read is performed, `rdData` holds its last value. This includes cycles with writes to any bank.
- R8: At most one bank drives the shared bus. Reads that alternate between banks show each bank's own word.
- R9: The same row and slot in different banks are separate storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rdReq | input | 1 | Read request |
| wrReq | input | 1 | Write request (wins over read) |
| addr | input | 15 | Word address {bank, row, slot} |
| wrData | input | 32 | Word to write |
| rdData | output | 32 | Shared read bus |
| blockActive | output | 32 | One-hot enable of the bank being accessed; zero bits are gated banks |

## Verification
The hardest case to reach is a change of bus ownership. It needs back-to-back reads that land in different banks, so that one bank gives up the bus in the same edge at which another loads its register. A combined read-and-write must also leave the bus untouched. The stimulus runs a pipelined stream of reads that alternates between bank 0 and bank 31 at the same row and slot. It then issues a combined request aimed at the bank that currently owns the bus. A random phase follows that mixes writes, reads and combined requests over a small pool of addresses. A behavioural model with an associative array tracks every cycle of this random phase.

// File: rtl/bank_pkg.sv
package bank_pkg;
  // Strobes from control to every bank; rd and wr are never both high.
  typedef struct packed {
    logic wr;
    logic rd;
  } bankStrobe_t;
endpackage

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import bank_pkg::*;
#(
  parameter int BLK_BITS = 5,
  parameter int ADDR_W   = 15,
  parameter int WORD_W   = 32,
  localparam int NUM_BLK = 1 << BLK_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rdReq,
  input  logic                wrReq,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   wrData,
  output bankStrobe_t         strobe,
  output logic [ADDR_W-1:0]   addrQ,
  output logic [WORD_W-1:0]   dataQ,
  output logic [NUM_BLK-1:0]  blkEn
);
  logic rdQ, wrQ;
  logic [BLK_BITS-1:0] blkField;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ   <= 1'b0;
      wrQ   <= 1'b0;
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      rdQ   <= rdReq;
      wrQ   <= wrReq;
      addrQ <= addr;
      dataQ <= wrData;
    end
  end

  // write wins: a combined request becomes a pure write
  always_comb begin
    strobe.wr = wrQ;
    strobe.rd = rdQ & ~wrQ;
  end

  assign blkField = addrQ[ADDR_W-1 -: BLK_BITS];

  for (genvar i = 0; i < NUM_BLK; i++) begin : g_en
    assign blkEn[i] = (rdQ | wrQ) && (blkField == BLK_BITS'(i));
  end

  // R3
  one_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq || wrReq) |=> ($countones(blkEn) == 1));
  // R3
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdReq || wrReq) |=> (blkEn == '0));
endmodule

// File: rtl/bank_block.sv
module bank_block
  import bank_pkg::*;
#(
  parameter int ROW_BITS = 7,
  parameter int COL_BITS = 3,
  parameter int WORD_W   = 32,
  localparam int ROWS    = 1 << ROW_BITS,
  localparam int COLS    = 1 << COL_BITS,
  localparam int ROW_W   = WORD_W * COLS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                en,
  input  bankStrobe_t         strobe,
  input  logic [ROW_BITS-1:0] row,
  input  logic [COL_BITS-1:0] col,
  input  logic [WORD_W-1:0]   wrWord,
  output logic [WORD_W-1:0]   busOut,
  output logic                ownsBus
);
  logic [ROW_W-1:0]  mem [ROWS];
  logic [ROW_W-1:0]  rowLine;
  logic [WORD_W-1:0] selWord;
  logic [WORD_W-1:0] outReg;

  always_ff @(posedge clk) begin
    if (en && strobe.wr) mem[row][int'(col)*WORD_W +: WORD_W] <= wrWord;
  end

  assign rowLine = mem[row];

  // one COLS-to-1 selector per output bit
  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    logic [COLS-1:0] colBits;
    for (genvar k = 0; k < COLS; k++) begin : g_col
      assign colBits[k] = rowLine[k*WORD_W + b];
    end
    assign selWord[b] = colBits[col];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg  <= '0;
      ownsBus <= 1'b0;
    end else if (strobe.rd) begin
      ownsBus <= en;
      if (en) outReg <= selWord;
    end
  end

  assign busOut = ownsBus ? outReg : '0;

  // R6
  wr_keeps_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (en && strobe.wr) |=> $stable(outReg));
endmodule

// File: rtl/bank_sram.sv
module bank_sram
  import bank_pkg::*;
#(
  parameter int BLK_BITS = 5,
  parameter int ROW_BITS = 7,
  parameter int COL_BITS = 3,
  parameter int WORD_W   = 32
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 rdReq,
  input  logic                                 wrReq,
  input  logic [BLK_BITS+ROW_BITS+COL_BITS-1:0] addr,
  input  logic [WORD_W-1:0]                    wrData,
  output logic [WORD_W-1:0]                    rdData,
  output logic [(1<<BLK_BITS)-1:0]             blockActive
);
  localparam int ADDR_W  = BLK_BITS + ROW_BITS + COL_BITS;
  localparam int NUM_BLK = 1 << BLK_BITS;

  bankStrobe_t         strobe;
  logic [ADDR_W-1:0]   addrQ;
  logic [WORD_W-1:0]   dataQ;
  logic [NUM_BLK-1:0]  blkEn;
  logic [NUM_BLK-1:0]  ownVec;
  logic [WORD_W-1:0]   busVec [NUM_BLK];

  bank_ctrl #(.BLK_BITS(BLK_BITS), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .wrReq(wrReq), .addr(addr),
    .wrData(wrData), .strobe(strobe), .addrQ(addrQ), .dataQ(dataQ), .blkEn(blkEn)
  );

  for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
    bank_block #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .WORD_W(WORD_W)) u_blk (
      .clk(clk), .rstN(rstN), .en(blkEn[i]), .strobe(strobe),
      .row(addrQ[COL_BITS +: ROW_BITS]), .col(addrQ[COL_BITS-1:0]),
      .wrWord(dataQ), .busOut(busVec[i]), .ownsBus(ownVec[i])
    );
  end

  // shared bus: owner-gated words merged
  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_BLK; i++) rdData = rdData | busVec[i];
  end

  assign blockActive = blkEn;

  // R8
  single_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ownVec));
  // R7
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rd |=> $stable(rdData));
endmodule

// File: tb/bank_sram_bench.sv
module bank_sram_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdReq = 1'b0, wrReq = 1'b0;
  logic [14:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] blockActive;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  bank_sram u_bank_sram (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .wrReq(wrReq), .addr(addr),
    .wrData(wrData), .rdData(rdData), .blockActive(blockActive)
  );

  // behavioural reference model
  logic [31:0] model [int];
  bit          pRd, pWr;
  logic [14:0] pAddr;
  logic [31:0] pData;
  logic [31:0] expData = '0;
  bit          expKnown = 1;

  always @(posedge clk) begin
    if (!rstN) begin
      pRd = 0; pWr = 0; expData = '0; expKnown = 1;
    end else begin
      if (pWr) model[int'(pAddr)] = pData;
      else if (pRd) begin
        if (model.exists(int'(pAddr))) begin expData = model[int'(pAddr)]; expKnown = 1; end
        else expKnown = 0;
      end
      pRd = rdReq; pWr = wrReq; pAddr = addr; pData = wrData;
    end
  end

  function automatic logic [31:0] expAct();
    return (pRd || pWr) ? (32'd1 << pAddr[14:10]) : 32'd0;
  endfunction

  // per-cycle comparison
  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if (blockActive !== expAct()) begin
        mismatched++;
        $display("FAIL R3 blockActive actual=%h expected=%h", blockActive, expAct());
      end
      if (expKnown) begin
        compared++;
        if (rdData !== expData) begin
          mismatched++;
          $display("FAIL R4 rdData actual=%h expected=%h", rdData, expData);
        end
      end
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [14:0] mk(input int b, input int r, input int c);
    return {5'(b), 7'(r), 3'(c)};
  endfunction

  task automatic op(input bit r, input bit w, input logic [14:0] a, input logic [31:0] d);
    rdReq = r; wrReq = w; addr = a; wrData = d;
    @(negedge clk);
  endtask

  task automatic idle();
    op(0, 0, addr, wrData);
  endtask

  task automatic readChk(input logic [14:0] a, input logic [31:0] exp, input string tag);
    op(1, 0, a, '0);
    idle();
    check(rdData, exp, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    @(negedge clk);
    check(rdData, 32'd0, "R1 rdData in reset");
    check(blockActive, 32'd0, "R1 blockActive in reset");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(rdData, 32'd0, "R1 rdData after reset");

    // R2: fill all slots of one row, read back each
    for (int c = 0; c < 8; c++) op(0, 1, mk(3, 5, c), 32'hA5A50000 + 32'(c));
    for (int c = 0; c < 8; c++) readChk(mk(3, 5, c), 32'hA5A50000 + 32'(c), "R2 slot map");
    op(0, 1, mk(3, 6, 2), 32'h0BADF00D);
    readChk(mk(3, 6, 2), 32'h0BADF00D, "R2 row field");
    readChk(mk(3, 5, 2), 32'hA5A50002, "R2 neighbour row");

    // R3: activity vector
    op(1, 0, mk(17, 0, 0), '0);
    check(blockActive, 32'h00020000, "R3 bank 17 active");
    idle();
    check(blockActive, 32'd0, "R3 all gated when idle");

    // R4: latency
    op(1, 0, mk(3, 5, 7), '0);
    check(rdData == 32'hA5A50007 ? 32'd1 : 32'd0, 32'd0, "R4 not yet visible");
    idle();
    check(rdData, 32'hA5A50007, "R4 visible after second edge");

    // R5: partial row write
    op(0, 1, mk(3, 5, 4), 32'hDEADBEEF);
    readChk(mk(3, 5, 4), 32'hDEADBEEF, "R5 new slot");
    readChk(mk(3, 5, 3), 32'hA5A50003, "R5 lower slot kept");
    readChk(mk(3, 5, 5), 32'hA5A50005, "R5 upper slot kept");

    // R9: same row/slot in different banks
    op(0, 1, mk(0, 9, 1), 32'h00000AAA);
    op(0, 1, mk(31, 9, 1), 32'hFFFFF555);
    readChk(mk(0, 9, 1), 32'h00000AAA, "R9 bank 0");
    readChk(mk(31, 9, 1), 32'hFFFFF555, "R9 bank 31");

    // R8: pipelined alternating reads
    op(1, 0, mk(0, 9, 1), '0);
    op(1, 0, mk(31, 9, 1), '0);
    check(rdData, 32'h00000AAA, "R8 bank 0 owns");
    op(1, 0, mk(0, 9, 1), '0);
    check(rdData, 32'hFFFFF555, "R8 bank 31 owns");
    idle();
    check(rdData, 32'h00000AAA, "R8 bank 0 again");

    // R6: combined request aimed at owning bank
    held = rdData;
    op(1, 1, mk(0, 9, 1), 32'h12345678);
    idle();
    check(rdData, held, "R6 bus unchanged by combined");
    readChk(mk(0, 9, 1), 32'h12345678, "R6 write performed");

    // R7: hold over idle and writes
    held = rdData;
    idle(); idle();
    check(rdData, held, "R7 hold idle");
    op(0, 1, mk(5, 1, 1), 32'h55550000);
    op(0, 1, mk(0, 9, 1), 32'h77777777);
    idle();
    check(rdData, held, "R7 hold over writes");

    // random mix over a small pool
    for (int n = 0; n < 400; n++) begin
      logic [14:0] a;
      int kind;
      a = mk(($urandom % 4) * 10, $urandom % 4, $urandom % 8);
      kind = $urandom % 4;
      if (kind == 0) op(0, 0, a, '0);
      else if (kind == 1 || !model.exists(int'(a))) op(0, 1, a, $urandom);
      else if (kind == 2) op(1, 0, a, '0);
      else op(1, 1, a, $urandom);
    end
    idle(); idle();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule